// File: doc/BRIEF.md
# Multi-CPU Interrupt Routing Controller

This block gathers 32 device interrupt lines and one local timer line per processor, and turns them into a 16-bit vector of priority-level outputs for each processor. A system register bank holds a pending word, a disabled word and the number of the processor that receives device interrupts. Each processor also has a small register bank holding its own pending word, where software can raise and drop software interrupts in the upper half of the word.

A parameter table gives each device bit a priority level from 0 to 15. A rising device line marks its bit pending at system level and marks the bit of its level in the chosen processor's pending word. A falling line clears both marks. The level outputs are registered. On each clock they are rebuilt from the current state: the levels of the enabled pending device bits, sent to the target processor only, ORed with the processor's own pending word shifted down by 16. Both banks use a simple word-addressed bus with a write strobe and a combinational read.

Top module: `irq_router_top`

## Requirements
- R1: After reset, the system pending word, the masked disabled word, the target and every processor pending word all read 0, and every level output is 0. The disabled word itself resets to 0x0FA2007F, so bits outside the valid mask 0xF05DFF80 stay disabled.
- R2: A rising edge on device line j whose level is L (nibble j of LEVEL_MAP) sets system pending bit j and bit L of the target processor's pending word. A falling edge clears both. Lines whose level is 0 have no effect.
- R3: While bit 31 of the disabled word (global disable) is set, no device interrupt reaches any level output. Setting and clearing bit 31 happens through system offsets 3 and 2.
- R4: A write to system offset 3 sets the disabled bits given in the data (valid-mask bits only) and clears the same system pending bits. A write to offset 2 clears disabled bits (valid-mask bits only). Offset 1 reads the disabled word ANDed with 0xF05DFF80.
- R5: System offset 0 reads the pending word with bit 31 forced to 0.
- R6: A write to system offset 4 keeps data bits 3:0 as the target, which reads back at offset 4. Only the target processor receives the device level term.
- R7: The level vector of processor c is the OR of the table levels of enabled pending device bits (c is the target, at least one such bit, global disable off) and bits 31:16 of c's pending word. It appears one clock after the state it is built from.
- R8: Processor offset 2 sets and offset 1 clears pending bits, with the data masked to 0xFFFE0000. Offset 0 reads the processor's pending word.
- R9: On a processor clear write with data bit 14 set, bit 31 of the pending word is cleared as well.
- R10: A rising edge on processor c's timer line sets system pending bit TIMER_BIT and, in c's pending word, the bit of TIMER_BIT's table level. A falling edge clears both.
- R11: Reads of undefined offsets on either bank return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_irq | input | 32 | Device interrupt lines, edge-detected |
| tmr_irq | input | NUM_CPUS | Local timer line per processor |
| sys_we | input | 1 | System bank write strobe |
| sys_addr | input | 3 | System bank word offset |
| sys_wdata | input | 32 | System bank write data |
| sys_rdata | output | 32 | System bank read data (combinational) |
| cpu_we | input | 1 | Processor bank write strobe |
| cpu_sel | input | 4 | Processor bank index |
| cpu_addr | input | 2 | Processor bank word offset |
| cpu_wdata | input | 32 | Processor bank write data |
| cpu_rdata | output | 32 | Processor bank read data (combinational) |
| lvl_out | output | NUM_CPUS*16 | Level vectors, processor c at bits c*16+15:c*16 |

## Verification
The assertions check on every cycle that the global disable leaves only the software term on the outputs, that a non-target processor never shows more than its own software bits, that a mask write leaves the written pending bits cleared, and that a software set write never touches the low 17 bits of a pending word. The bench scenarios cover the value-level behaviour that needs chosen stimulus: the level table mapping and its ignored level-0 entries, the permanently disabled bits, the target steering, the bit-14 clear quirk, the timer routing through the target, and the undefined offsets.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_N   = 32;
  localparam int LVL_N   = 16;
  localparam int LVL_W   = 4;
  localparam int MAP_W   = SRC_N * LVL_W;
  localparam int GLOB_BIT  = 31;
  localparam int QUIRK_BIT = 14;

  typedef logic [31:0]      word_t;
  typedef logic [LVL_N-1:0] lvl_vec_t;

  localparam word_t SYS_VALID = ~32'h0FA2007F;
  localparam word_t SW_MASK   = 32'hFFFE0000;

  typedef enum logic [2:0] {
    SYS_PEND = 3'd0, SYS_DIS = 3'd1, SYS_EN = 3'd2, SYS_MASK = 3'd3, SYS_TGT = 3'd4
  } sys_off_e;

  typedef enum logic [1:0] {
    CPU_PEND = 2'd0, CPU_CLR = 2'd1, CPU_SET = 2'd2
  } cpu_off_e;

  function automatic logic [LVL_W-1:0] level_of(input logic [MAP_W-1:0] map, input int j);
    return map[j*LVL_W +: LVL_W];
  endfunction

  // one-hot OR of table levels for every set source bit
  function automatic lvl_vec_t fan_levels(input word_t src, input logic [MAP_W-1:0] map);
    lvl_vec_t v = '0;
    for (int j = 0; j < SRC_N; j++)
      if (src[j]) v[map[j*LVL_W +: LVL_W]] = 1'b1;
    return v;
  endfunction

  // clear-port data: bit 14 extends to bit 31, then software mask
  function automatic word_t sw_clear_bits(input word_t d);
    word_t t = d;
    if (d[QUIRK_BIT]) t[GLOB_BIT] = 1'b1;
    return t & SW_MASK;
  endfunction
endpackage

// File: rtl/irq_sys_bank.sv
module irq_sys_bank
  import irq_router_pkg::*;
#(
  parameter int              NUM_CPUS  = 4,
  parameter logic [MAP_W-1:0] LEVEL_MAP = '0,
  parameter int              TIMER_BIT = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  word_t               dev_irq,
  input  logic [NUM_CPUS-1:0] tmr_irq,
  input  logic                sys_we,
  input  logic [2:0]          sys_addr,
  input  word_t               sys_wdata,
  output word_t               sys_rdata,
  output word_t               pend_q,
  output word_t               dis_q,
  output logic [3:0]          tgt_q,
  output word_t               dev_rise,
  output word_t               dev_fall,
  output logic [NUM_CPUS-1:0] tmr_rise,
  output logic [NUM_CPUS-1:0] tmr_fall
);
  word_t               dev_q;
  logic [NUM_CPUS-1:0] tmr_q;
  word_t               live;
  word_t               wr_bits, pend_set, pend_clr;
  logic                wr_en, wr_mask, wr_tgt;

  for (genvar j = 0; j < SRC_N; j++) begin : g_live
    assign live[j] = |LEVEL_MAP[j*LVL_W +: LVL_W];
  end

  assign dev_rise = dev_irq & ~dev_q & live;
  assign dev_fall = ~dev_irq & dev_q & live;
  assign tmr_rise = tmr_irq & ~tmr_q;
  assign tmr_fall = ~tmr_irq & tmr_q;

  assign wr_bits = sys_wdata & SYS_VALID;
  assign wr_en   = sys_we && (sys_addr == SYS_EN);
  assign wr_mask = sys_we && (sys_addr == SYS_MASK);
  assign wr_tgt  = sys_we && (sys_addr == SYS_TGT);

  assign pend_set = dev_rise | ((|tmr_rise) ? (word_t'(1) << TIMER_BIT) : '0);
  assign pend_clr = dev_fall | ((|tmr_fall) ? (word_t'(1) << TIMER_BIT) : '0)
                  | (wr_mask ? wr_bits : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q  <= '0;
      tmr_q  <= '0;
      pend_q <= '0;
      dis_q  <= ~SYS_VALID;
      tgt_q  <= '0;
    end else begin
      dev_q  <= dev_irq;
      tmr_q  <= tmr_irq;
      pend_q <= (pend_q | pend_set) & ~pend_clr;
      if (wr_en)   dis_q <= dis_q & ~wr_bits;
      if (wr_mask) dis_q <= dis_q | wr_bits;
      if (wr_tgt)  tgt_q <= sys_wdata[3:0];
    end
  end

  always_comb begin
    unique case (sys_addr)
      SYS_PEND: sys_rdata = pend_q & ~(word_t'(1) << GLOB_BIT);
      SYS_DIS:  sys_rdata = dis_q & SYS_VALID;
      SYS_TGT:  sys_rdata = {28'd0, tgt_q};
      default:  sys_rdata = '0;
    endcase
  end

  // R4: bits named by a mask write are not pending on the next cycle
  a_r4_mask_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((pend_q & $past(wr_bits)) == '0));
endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_router_pkg::*;
#(
  parameter int               CPU_ID    = 0,
  parameter logic [MAP_W-1:0] LEVEL_MAP = '0,
  parameter int               TIMER_BIT = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tgt,
  input  word_t      dev_rise,
  input  word_t      dev_fall,
  input  logic       tmr_rise,
  input  logic       tmr_fall,
  input  logic       we,
  input  logic [1:0] addr,
  input  word_t      wdata,
  output word_t      pend_q
);
  localparam word_t TMR_LBIT = word_t'(1) << level_of(LEVEL_MAP, TIMER_BIT);

  logic  is_tgt, hw_evt;
  word_t hw_set, hw_clr, sw_set, sw_clr;

  assign is_tgt = (tgt == 4'(CPU_ID));
  assign hw_set = (is_tgt ? word_t'(fan_levels(dev_rise, LEVEL_MAP)) : '0)
                | (tmr_rise ? TMR_LBIT : '0);
  assign hw_clr = (is_tgt ? word_t'(fan_levels(dev_fall, LEVEL_MAP)) : '0)
                | (tmr_fall ? TMR_LBIT : '0);
  assign hw_evt = |(hw_set | hw_clr);
  assign sw_set = (we && addr == CPU_SET) ? (wdata & SW_MASK) : '0;
  assign sw_clr = (we && addr == CPU_CLR) ? sw_clear_bits(wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q | hw_set | sw_set) & ~(hw_clr | sw_clr);
  end

  // R8: a software set write cannot reach bits 16:0
  a_r8_set_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == CPU_SET && !hw_evt) |=> $stable(pend_q[16:0]));
endmodule

// File: rtl/irq_lvl_out.sv
module irq_lvl_out
  import irq_router_pkg::*;
#(
  parameter int               CPU_ID    = 0,
  parameter logic [MAP_W-1:0] LEVEL_MAP = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  word_t      sys_pend,
  input  word_t      sys_dis,
  input  logic [3:0] tgt,
  input  word_t      cpu_pend,
  output lvl_vec_t   lvl_q
);
  word_t    en_pend;
  lvl_vec_t dev_term, sw_term;
  logic     route_ok;

  assign en_pend  = sys_pend & ~sys_dis;
  assign route_ok = (tgt == 4'(CPU_ID)) && (|en_pend) && !sys_dis[GLOB_BIT];
  assign dev_term = route_ok ? fan_levels(en_pend, LEVEL_MAP) : '0;
  assign sw_term  = cpu_pend[31:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= dev_term | sw_term;
  end

  // R3: global disable leaves only the software term
  a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    sys_dis[GLOB_BIT] |=> (lvl_q == $past(cpu_pend[31:16])));
  // R6: a processor that is not the target sees only its own software bits
  a_r6_non_target: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt != 4'(CPU_ID)) |=> ((lvl_q & ~$past(cpu_pend[31:16])) == '0));
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int               NUM_CPUS  = 4,
  parameter logic [MAP_W-1:0] LEVEL_MAP = 128'hFEDCBA9876543210_FEDCBA9876543210,
  parameter int               TIMER_BIT = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [31:0]               dev_irq,
  input  logic [NUM_CPUS-1:0]       tmr_irq,
  input  logic                      sys_we,
  input  logic [2:0]                sys_addr,
  input  logic [31:0]               sys_wdata,
  output logic [31:0]               sys_rdata,
  input  logic                      cpu_we,
  input  logic [3:0]                cpu_sel,
  input  logic [1:0]                cpu_addr,
  input  logic [31:0]               cpu_wdata,
  output logic [31:0]               cpu_rdata,
  output logic [NUM_CPUS*LVL_N-1:0] lvl_out
);
  word_t               pend_q, dis_q, dev_rise, dev_fall;
  logic [3:0]          tgt_q;
  logic [NUM_CPUS-1:0] tmr_rise, tmr_fall;
  word_t               cpu_pend [NUM_CPUS];

  irq_sys_bank #(.NUM_CPUS(NUM_CPUS), .LEVEL_MAP(LEVEL_MAP), .TIMER_BIT(TIMER_BIT)) u_sys (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
    .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q),
    .dev_rise(dev_rise), .dev_fall(dev_fall), .tmr_rise(tmr_rise), .tmr_fall(tmr_fall)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    irq_cpu_bank #(.CPU_ID(c), .LEVEL_MAP(LEVEL_MAP), .TIMER_BIT(TIMER_BIT)) u_bank (
      .clk(clk), .rst_n(rst_n), .tgt(tgt_q),
      .dev_rise(dev_rise), .dev_fall(dev_fall),
      .tmr_rise(tmr_rise[c]), .tmr_fall(tmr_fall[c]),
      .we(cpu_we && (cpu_sel == 4'(c))), .addr(cpu_addr), .wdata(cpu_wdata),
      .pend_q(cpu_pend[c])
    );
    irq_lvl_out #(.CPU_ID(c), .LEVEL_MAP(LEVEL_MAP)) u_out (
      .clk(clk), .rst_n(rst_n), .sys_pend(pend_q), .sys_dis(dis_q), .tgt(tgt_q),
      .cpu_pend(cpu_pend[c]), .lvl_q(lvl_out[c*LVL_N +: LVL_N])
    );
  end

  always_comb begin
    cpu_rdata = '0;
    for (int c = 0; c < NUM_CPUS; c++)
      if (cpu_sel == 4'(c) && cpu_addr == CPU_PEND) cpu_rdata = cpu_pend[c];
  end
endmodule

// File: tb/irq_router_top_tb_top.sv
`timescale 1ns/1ps
module irq_router_top_tb_top;
  localparam int NC = 4;

  logic          clk = 0, rst_n = 0;
  logic [31:0]   dev_irq = '0;
  logic [NC-1:0] tmr_irq = '0;
  logic          sys_we = 0, cpu_we = 0;
  logic [2:0]    sys_addr = '0;
  logic [31:0]   sys_wdata = '0, cpu_wdata = '0;
  logic [31:0]   sys_rdata, cpu_rdata;
  logic [3:0]    cpu_sel = '0;
  logic [1:0]    cpu_addr = '0;
  logic [NC*16-1:0] lvl_out;

  int checks = 0, errors = 0;
  bit done = 0;

  irq_router_top dut_i (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .tmr_irq(tmr_irq),
    .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .cpu_we(cpu_we), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .lvl_out(lvl_out)
  );

  always #2 clk = ~clk;

  // bench view of the table: level of bit j is j mod 16
  function automatic logic [15:0] lvl_bit(input int j);
    return 16'(1) << (j % 16);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic sys_wr(input logic [2:0] a, input logic [31:0] d);
    sys_we = 1; sys_addr = a; sys_wdata = d;
    tick(1);
    sys_we = 0;
  endtask

  task automatic sys_rd(input logic [2:0] a, output logic [31:0] d);
    sys_addr = a; #0.5; d = sys_rdata;
  endtask

  task automatic cpu_wr(input logic [3:0] s, input logic [1:0] a, input logic [31:0] d);
    cpu_we = 1; cpu_sel = s; cpu_addr = a; cpu_wdata = d;
    tick(1);
    cpu_we = 0;
  endtask

  task automatic cpu_rd(input logic [3:0] s, input logic [1:0] a, output logic [31:0] d);
    cpu_sel = s; cpu_addr = a; #0.5; d = cpu_rdata;
  endtask

  function automatic logic [31:0] lv(input int c);
    return {16'd0, lvl_out[c*16 +: 16]};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    sys_rd(0, d); chk("R1 pend", d, 0);
    sys_rd(1, d); chk("R1 dis", d, 0);
    sys_rd(4, d); chk("R1 tgt", d, 0);
    for (int c = 0; c < NC; c++) begin
      cpu_rd(4'(c), 0, d); chk("R1 cpu pend", d, 0);
      chk("R1 lvl", lv(c), 0);
    end
  endtask

  task automatic t_device;
    logic [31:0] d;
    dev_irq[9] = 1; tick(2);
    sys_rd(0, d); chk("R2 sys pend rise", d, 32'h200);
    cpu_rd(0, 0, d); chk("R2 cpu pend rise", d, 32'(lvl_bit(9)));
    chk("R7 lvl dev", lv(0), 32'(lvl_bit(9)));
    dev_irq[9] = 0; tick(2);
    sys_rd(0, d); chk("R2 sys pend fall", d, 0);
    cpu_rd(0, 0, d); chk("R2 cpu pend fall", d, 0);
    chk("R7 lvl fall", lv(0), 0);
    // bit 16 has table level 0: ignored
    dev_irq[16] = 1; tick(2);
    sys_rd(0, d); chk("R2 level0 ignored", d, 0);
    cpu_rd(0, 0, d); chk("R2 level0 cpu", d, 0);
    dev_irq[16] = 0;
    // bit 17 lies outside the valid mask: pending but never enabled
    dev_irq[17] = 1; tick(2);
    sys_rd(0, d); chk("R1 invalid pend", d, 32'h20000);
    chk("R1 invalid stays disabled", lv(0), 0);
    dev_irq[17] = 0; tick(2);
  endtask

  task automatic t_target;
    logic [31:0] d;
    sys_wr(4, 32'h12);
    sys_rd(4, d); chk("R6 tgt low bits", d, 32'h2);
    dev_irq[10] = 1; tick(2);
    cpu_rd(2, 0, d); chk("R6 tgt cpu pend", d, 32'(lvl_bit(10)));
    chk("R6 tgt lvl", lv(2), 32'(lvl_bit(10)));
    chk("R6 other lvl", lv(0), 0);
    dev_irq[10] = 0; tick(2);
    chk("R6 tgt lvl fall", lv(2), 0);
    sys_wr(4, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    dev_irq[12] = 1; tick(2);
    chk("R7 lvl 12", lv(0), 32'(lvl_bit(12)));
    sys_wr(3, 32'h1000); tick(1);
    sys_rd(0, d); chk("R4 mask clears pend", d, 0);
    sys_rd(1, d); chk("R4 dis read", d, 32'h1000);
    chk("R4 lvl masked", lv(0), 0);
    sys_wr(3, 32'hFFFFFFFF);
    sys_rd(1, d); chk("R4 dis valid only", d, 32'hF05DFF80);
    sys_wr(2, 32'hFFFFFFFF);
    sys_rd(1, d); chk("R4 enable all", d, 0);
    dev_irq[12] = 0; tick(2);
  endtask

  task automatic t_global;
    logic [31:0] d;
    sys_wr(3, 32'h80000000);
    sys_rd(1, d); chk("R3 glob read", d, 32'h80000000);
    dev_irq[11] = 1; dev_irq[31] = 1; tick(2);
    sys_rd(0, d); chk("R5 bit31 hidden", d, 32'h800);
    chk("R3 glob blocks", lv(0), 0);
    sys_wr(2, 32'h80000000); tick(1);
    chk("R7 glob released", lv(0), 32'(lvl_bit(11) | lvl_bit(31)));
    dev_irq[11] = 0; dev_irq[31] = 0; tick(2);
    chk("R7 lvl cleared", lv(0), 0);
  endtask

  task automatic t_soft;
    logic [31:0] d;
    cpu_wr(1, 2, 32'hFFFFFFFF); tick(1);
    cpu_rd(1, 0, d); chk("R8 set masked", d, 32'hFFFE0000);
    chk("R7 sw term", lv(1), 32'hFFFE);
    cpu_wr(1, 1, 32'h00020000); tick(1);
    cpu_rd(1, 0, d); chk("R8 clear", d, 32'hFFFC0000);
    chk("R7 sw term clr", lv(1), 32'hFFFC);
    cpu_wr(1, 1, 32'h00004000); tick(1);
    cpu_rd(1, 0, d); chk("R9 quirk clear 31", d, 32'h7FFC0000);
    chk("R9 lvl", lv(1), 32'h7FFC);
    cpu_wr(1, 1, 32'hFFFFFFFF);
    cpu_rd(1, 0, d); chk("R8 clear all", d, 0);
    cpu_wr(1, 2, 32'h0001FFFF);
    cpu_rd(1, 0, d); chk("R8 low set ignored", d, 0);
  endtask

  task automatic t_timer;
    logic [31:0] d;
    tmr_irq[3] = 1; tick(2);
    sys_rd(0, d); chk("R10 sys bit", d, 32'h4000);
    cpu_rd(3, 0, d); chk("R10 cpu bit", d, 32'(lvl_bit(14)));
    chk("R10 routed to target", lv(0), 32'(lvl_bit(14)));
    chk("R10 timer cpu lvl", lv(3), 0);
    tmr_irq[3] = 0; tick(2);
    sys_rd(0, d); chk("R10 sys clr", d, 0);
    cpu_rd(3, 0, d); chk("R10 cpu clr", d, 0);
    chk("R10 lvl clr", lv(0), 0);
  endtask

  task automatic t_undef;
    logic [31:0] d;
    for (int a = 5; a < 8; a++) begin
      sys_rd(3'(a), d); chk("R11 sys undef read", d, 0);
    end
    sys_wr(0, 32'hFFFFFFFF); sys_wr(1, 32'hFFFFFFFF); sys_wr(7, 32'hFFFFFFFF);
    sys_rd(0, d); chk("R11 pend untouched", d, 0);
    sys_rd(1, d); chk("R11 dis untouched", d, 0);
    sys_rd(4, d); chk("R11 tgt untouched", d, 0);
    cpu_wr(0, 0, 32'hFFFFFFFF); cpu_wr(0, 3, 32'hFFFFFFFF);
    cpu_rd(0, 0, d); chk("R11 cpu untouched", d, 0);
    cpu_rd(0, 3, d); chk("R11 cpu undef read", d, 0);
    tick(1);
    chk("R11 lvl untouched", lv(0), 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_device();
    t_target();
    t_mask();
    t_global();
    t_soft();
    t_timer();
    t_undef();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule